// File: doc/BRIEF.md
# Prescaled Multi-Mode Compare Timer

This block is an up-counting timer with a programmable prescaler in front of it. Every PSC+1 timer clocks the prescaler emits one tick, and each tick advances the count by one. The count is checked against a programmable compare value. A match raises a sticky time-out flag, which can drive an interrupt line. One comparator serves four counting modes: one-shot, periodic, toggle-output and free-running continuous. Software starts the count, suspends it and resumes it, clears it with a self-clearing command, and clears the flag, all through a small register port.

The register port carries control and status only, so it is a plain single-cycle write strobe with a combinational read. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge on which `wr_en` is high. The register words are as follows:
- Address 0 is the control word. Its fields, from bit 0 upward, are the prescale value, the mode, the interrupt enable, the run bit, the clear command and the read-only active bit.
- Address 1 is the compare value.
- Address 2 is status. Bit 0 is the time-out flag.
- Address 3 is the count, and it is read-only.

The count width and the prescale width are parameters, with defaults of 24 and 8 bits.

Top module: `cmp_timer`

## Requirements
- R1: While the run bit (control bit PSC_W+3) is 1, the count advances by one every PSC+1 clocks, where PSC is control bits [PSC_W-1:0]. PSC = 0 gives one step per clock.
- R2: A control write whose PSC field differs from the stored value clears the prescale counter and the count. A control write that keeps the same PSC leaves both untouched.
- R3: The mode field is control bits [PSC_W+1:PSC_W]: 0 = one-shot, 1 = periodic, 2 = toggle, 3 = continuous. In periodic mode a match occurs on the tick that would bring the count to the compare value. That same tick returns the count to 0, so the count cycles 0..CMP-1 and the time-out period is (PSC+1)*CMP clocks.
- R4: A match sets the time-out flag (status bit 0), and the flag stays set until a status write with bit 0 = 1 clears it. A status write with bit 0 = 0 has no effect. A match wins over a clear in the same cycle.
- R5: The `irq` output is 1 exactly when the flag is 1 and the interrupt enable (control bit PSC_W+2) is 1.
- R6: In one-shot mode the match clears the run bit, and the count returns to 0 and stays there.
- R7: Clearing the run bit holds the count. Setting it again resumes counting from the held value.
- R8: A write to the compare value restarts the count and the prescaler from 0 in modes 0 to 2. In continuous mode the count carries on undisturbed.
- R9: A control write with bit PSC_W+4 = 1 clears the prescaler, the count and the run bit. The bit itself is not stored and reads back as 0.
- R10: `tgl_out` inverts on every match in toggle mode and never changes in the other modes. It resets to 0.
- R11: In continuous mode a match sets the flag without disturbing the count, and the count wraps from its maximum value to 0.
- R12: A compare value of 0 or 1 behaves as 2.
- R13: `active` (also control bit PSC_W+5 on read) equals the run bit as it was two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Combinational register read data |
| count | output | CNT_W | Current count |
| tmo_flag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Interrupt line, flag gated by the enable |
| tgl_out | output | 1 | Toggle-mode output |
| active | output | 1 | Run bit delayed by two clocks |

## Verification
The assertions check on every cycle the relations that hold at all times:
- the flag persists until it is cleared by write-one;
- the interrupt is never raised without the flag;
- the count is frozen while stopped;
- the run bit is dropped when a one-shot match occurs;
- `active` lags the run bit by exactly two clocks;
- the toggle output moves only on a match.

Only the bench scenarios can show the arithmetic:
- the exact period (PSC+1)*CMP over a sweep of prescale and compare values;
- the wrap of the count in continuous mode;
- the mode-dependent reaction to compare writes and prescale writes;
- the floor of 2 on the compare value;
- resumption from the held count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_TOGGLE   = 2'd2,
    MODE_CONT     = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              oneshot_done,
  input  logic [CNT_W-1:0]  count,
  input  logic              tmo_flag,
  input  logic              active,
  output logic [PSC_W-1:0]  psc,
  output tmr_mode_e         mode,
  output logic              irq_en,
  output logic              run,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              restart,
  output logic              flag_clr
);

  localparam int BIT_MODE = PSC_W;
  localparam int BIT_IE   = PSC_W + 2;
  localparam int BIT_RUN  = PSC_W + 3;
  localparam int BIT_CLR  = PSC_W + 4;
  localparam int BIT_ACT  = PSC_W + 5;
  localparam int CTRL_W   = PSC_W + 6;

  logic ctrl_wr, cmp_wr, clr_cmd, psc_new, cmp_restart;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
  assign cmp_wr      = wr_en && (wr_addr == ADDR_CMP);
  assign flag_clr    = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
  assign clr_cmd     = ctrl_wr && wr_data[BIT_CLR];
  assign psc_new     = ctrl_wr && (wr_data[PSC_W-1:0] != psc);
  assign cmp_restart = cmp_wr && (mode != MODE_CONT);
  assign restart     = clr_cmd || psc_new || cmp_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc     <= '0;
      mode    <= MODE_ONESHOT;
      irq_en  <= 1'b0;
      run     <= 1'b0;
      cmp_val <= '0;
    end else begin
      if (ctrl_wr) begin
        psc    <= wr_data[PSC_W-1:0];
        mode   <= tmr_mode_e'(wr_data[BIT_MODE +: 2]);
        irq_en <= wr_data[BIT_IE];
        run    <= wr_data[BIT_RUN] && !wr_data[BIT_CLR];
      end else if (oneshot_done) begin
        run <= 1'b0;
      end
      if (cmp_wr) begin
        cmp_val <= wr_data[CNT_W-1:0];
      end
    end
  end

  logic [CTRL_W-1:0] ctrl_rd;
  assign ctrl_rd = {active, 1'b0, run, irq_en, mode, psc};

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL: rd_data = DATA_W'(ctrl_rd);
      ADDR_CMP:  rd_data = DATA_W'(cmp_val);
      ADDR_STAT: rd_data = DATA_W'(tmo_flag);
      default:   rd_data = DATA_W'(count);
    endcase
  end

  logic unused_wr_bits;
  assign unused_wr_bits = &{1'b0, wr_data};

endmodule

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;
  logic             wrap;

  assign wrap = (div_q == psc);
  assign tick = run && wrap && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= wrap ? '0 : div_q + 1'b1;
    end
  end

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             match
);

  localparam logic [CNT_W-1:0] CMP_FLOOR = CNT_W'(2);

  logic [CNT_W-1:0] cmp_eff, nxt;

  assign cmp_eff = (cmp_val < CMP_FLOOR) ? CMP_FLOOR : cmp_val;
  assign nxt     = count + 1'b1;
  assign match   = tick && (nxt == cmp_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (tick) begin
      if (match && (mode != MODE_CONT)) count <= '0;
      else                              count <= nxt;
    end
  end

endmodule

// File: rtl/cmp_timer_events.sv
module cmp_timer_events
  import cmp_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      match,
  input  tmr_mode_e mode,
  input  logic      flag_clr,
  input  logic      run,
  output logic      tmo_flag,
  output logic      tgl_out,
  output logic      active
);

  localparam int ACT_DLY = 2;

  logic [ACT_DLY-1:0] run_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      tgl_out  <= 1'b0;
      run_sh   <= '0;
    end else begin
      if (match)         tmo_flag <= 1'b1;
      else if (flag_clr) tmo_flag <= 1'b0;
      if (match && (mode == MODE_TOGGLE)) tgl_out <= !tgl_out;
      run_sh <= {run_sh[ACT_DLY-2:0], run};
    end
  end

  assign active = run_sh[ACT_DLY-1];

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              tmo_flag,
  output logic              irq,
  output logic              tgl_out,
  output logic              active
);

  logic [PSC_W-1:0] psc_w;
  tmr_mode_e        mode_w;
  logic             irq_en_w, run_w, restart_w, flag_clr_w, tick_w, match_w;
  logic             oneshot_done_w;
  logic [CNT_W-1:0] cmp_w;

  assign oneshot_done_w = match_w && (mode_w == MODE_ONESHOT);
  assign irq            = tmo_flag && irq_en_w;

  cmp_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .oneshot_done(oneshot_done_w), .count(count), .tmo_flag(tmo_flag),
    .active(active), .psc(psc_w), .mode(mode_w), .irq_en(irq_en_w),
    .run(run_w), .cmp_val(cmp_w), .restart(restart_w), .flag_clr(flag_clr_w)
  );

  cmp_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_w), .restart(restart_w),
    .psc(psc_w), .tick(tick_w)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .restart(restart_w),
    .mode(mode_w), .cmp_val(cmp_w), .count(count), .match(match_w)
  );

  cmp_timer_events u_evt (
    .clk(clk), .rst_n(rst_n), .match(match_w), .mode(mode_w),
    .flag_clr(flag_clr_w), .run(run_w), .tmo_flag(tmo_flag),
    .tgl_out(tgl_out), .active(active)
  );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic              tmo_flag,
  input logic              irq,
  input logic              tgl_out,
  input logic              active,
  input logic              run_q,
  input logic [1:0]        mode_q,
  input logic              restart
);

  logic clr_wr, ctrl_wr;
  assign clr_wr  = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  // R4
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !clr_wr |=> tmo_flag);

  // R5
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_flag |-> !irq);

  // R6
  a_r6_oneshot_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) && (mode_q == MODE_ONESHOT) && !$past(ctrl_wr) |-> !run_q);

  // R7
  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !restart |=> $stable(count));

  // R10
  a_r10_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgl_out) |-> tmo_flag);

  // R13
  a_r13_active_lag: assert property (@(posedge clk) disable iff (!rst_n)
    active == $past(run_q, 2));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .tmo_flag(tmo_flag), .irq(irq),
  .tgl_out(tgl_out), .active(active), .run_q(run_w), .mode_q(mode_w),
  .restart(restart_w)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;

  localparam int CW = 8;
  localparam int PW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, wr_en;
  logic [1:0]    wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [CW-1:0] count;
  logic          tmo_flag, irq, tgl_out, active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer #(.CNT_W(CW), .PSC_W(PW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .tmo_flag(tmo_flag), .irq(irq), .tgl_out(tgl_out),
    .active(active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge, returns at the following negedge.
  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  function automatic int ctl(int p, int m, int ie, int run, int clr);
    return p | (m << 4) | (ie << 6) | (run << 7) | (clr << 8);
  endfunction

  task automatic setup(input int p, input int m, input int c);
    wr(2'd0, ctl(p, m, 0, 0, 1));
    wr(2'd1, c);
    wr(2'd2, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, c, k;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R4 reset flag", tmo_flag, 0);
    check("R5 reset irq", irq, 0);
    check("R10 reset toggle", tgl_out, 0);
    check("R13 reset active", active, 0);
    check("R1 reset count", count, 0);
    rd(2'd0, v);
    check("R9 reset control", v, 0);

    // R1 R3 R13: periodic sweep over prescale and compare
    for (int p = 0; p < 4; p++) begin
      for (int cm = 2; cm < 6; cm++) begin
        setup(p, 1, cm);
        wr(2'd0, ctl(p, 1, 0, 1, 0));
        check("R3 count at start", count, 0);
        for (int n = 1; n <= 2 * cm * (p + 1); n++) begin
          @(negedge clk);
          check("R3 periodic count", count, (n / (p + 1)) % cm);
          check("R1 period flag", tmo_flag, (n >= cm * (p + 1)) ? 1 : 0);
          check("R13 active lag", active, (n >= 2) ? 1 : 0);
        end
      end
    end

    // R6 one-shot
    setup(1, 0, 3);
    wr(2'd0, ctl(1, 0, 0, 1, 0));
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      check("R6 one-shot count", count, (n < 6) ? n / 2 : 0);
      check("R6 one-shot flag", tmo_flag, (n >= 6) ? 1 : 0);
    end
    rd(2'd0, v);
    check("R6 run cleared", (v >> 7) & 1, 0);
    check("R13 active after one-shot", (v >> 9) & 1, 0);

    // R10 toggle
    check("R10 no toggle outside toggle mode", tgl_out, 0);
    setup(0, 2, 3);
    wr(2'd0, ctl(0, 2, 0, 1, 0));
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      check("R10 toggle output", tgl_out, (n / 3) & 1);
      check("R3 toggle count", count, n % 3);
    end

    // R11 continuous with wrap
    setup(0, 3, 5);
    wr(2'd0, ctl(0, 3, 0, 1, 0));
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      check("R11 continuous count", count, n % 256);
      check("R11 continuous flag", tmo_flag, (n >= 5) ? 1 : 0);
    end
    // R8 compare write in continuous mode leaves count running
    c = int'(count);
    wr(2'd1, 9);
    check("R8 continuous compare write", count, (c + 1) % 256);
    wr(2'd2, 1);
    check("R4 flag cleared", tmo_flag, 0);
    c = int'(count);
    k = (9 - c) & 255;
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      check("R11 match after wrap", tmo_flag, (j == k) ? 1 : 0);
    end

    // R8 compare write in periodic mode restarts
    setup(0, 1, 50);
    wr(2'd0, ctl(0, 1, 0, 1, 0));
    repeat (10) @(negedge clk);
    check("R1 count before restart", count, 10);
    wr(2'd1, 50);
    check("R8 periodic compare restart", count, 0);
    @(negedge clk);
    check("R8 count resumes after restart", count, 1);

    // R2 prescale writes
    c = int'(count);
    wr(2'd0, ctl(0, 1, 0, 1, 0));
    check("R2 same prescale keeps count", count, c + 1);
    wr(2'd0, ctl(2, 1, 0, 1, 0));
    check("R2 new prescale clears count", count, 0);
    repeat (2) @(negedge clk);
    check("R2 prescaler cleared", count, 0);
    @(negedge clk);
    check("R2 first tick after prescale write", count, 1);

    // R7 stop and resume
    wr(2'd0, ctl(0, 1, 0, 1, 0));
    check("R7 prescale 0 restart", count, 0);
    repeat (7) @(negedge clk);
    wr(2'd0, ctl(0, 1, 0, 0, 0));
    check("R7 count at stop", count, 8);
    repeat (10) @(negedge clk);
    check("R7 count held", count, 8);
    check("R13 active low when stopped", active, 0);
    wr(2'd0, ctl(0, 1, 0, 1, 0));
    check("R7 resume from held", count, 8);
    repeat (4) @(negedge clk);
    check("R7 count after resume", count, 12);

    // R9 clear command
    wr(2'd0, ctl(0, 1, 0, 1, 1));
    check("R9 clear count", count, 0);
    rd(2'd0, v);
    check("R9 run cleared", (v >> 7) & 1, 0);
    check("R9 clear bit reads 0", (v >> 8) & 1, 0);
    repeat (3) @(negedge clk);
    check("R9 count stays 0", count, 0);

    // R4 R5 flag and interrupt
    wr(2'd1, 2);
    wr(2'd2, 1);
    wr(2'd0, ctl(0, 1, 0, 1, 0));
    repeat (3) @(negedge clk);
    check("R4 flag set", tmo_flag, 1);
    check("R5 irq masked", irq, 0);
    wr(2'd0, ctl(0, 1, 1, 1, 0));
    check("R5 irq enabled", irq, 1);
    wr(2'd0, ctl(0, 1, 1, 0, 0));
    wr(2'd2, 0);
    check("R4 write 0 ignored", tmo_flag, 1);
    rd(2'd2, v);
    check("R4 status read", v & 1, 1);
    wr(2'd2, 1);
    check("R4 write 1 clears", tmo_flag, 0);
    check("R5 irq follows flag", irq, 0);

    // R12 compare floor
    for (int cv = 0; cv < 2; cv++) begin
      setup(0, 1, cv);
      wr(2'd0, ctl(0, 1, 0, 1, 0));
      for (int n = 1; n <= 6; n++) begin
        @(negedge clk);
        check("R12 floor count", count, n % 2);
        check("R12 floor flag", tmo_flag, (n >= 2) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule